// File: doc/BRIEF.md
# Loop-Disconnect Pulse Dialer

This block dials a decimal digit on a telephone line by interrupting the loop current. It turns the digit into a train of line breaks, each followed by a make interval, on a dial pulse drive that feeds an open-drain transistor. The same drive also produces a timed flash break, whichever dialing mode the rest of the telephone uses. A pause request keeps the block busy for a fixed idle interval. Hook sensing and keypad scanning are handled elsewhere.

All timing is counted in milliseconds from an external one-cycle tick. The pulse rate is selectable: 10 or 20 pulses per second. The make-to-break proportion is also selectable. A mute drive stays active for the whole of a digit or a flash, so the speech path can be silenced. A `ready` / `done` pair hands requests in and reports their completion.

Top module: `pulse_dialer`

## Requirements
- R1: After reset `ready` is 1 and `dialPulse`, `muteOn` and `done` are 0.
- R2: When `digitStart` is accepted, digit 1 to 9 produces that number of break pulses on `dialPulse`, and digit 0 produces ten. A digit value of 10 to 15 is ignored: `ready` stays 1 and neither drive rises.
- R3: The pulse period is 100 ms when `rateSel`=0 and 50 ms when `rateSel`=1. With `ratioSel`=0 each break lasts 60 % of the period and each make lasts 40 % (60/40 ms or 30/20 ms). With `ratioSel`=1 each break is two thirds of the period, rounded (67/33 ms or 33/17 ms).
- R4: After the last break of a digit, the line stays made for one make interval plus one full period before `done`.
- R5: An accepted `flashReq` holds `dialPulse` high for 73, 100, 300 or 600 ms for `flashCode` 0, 1, 2 or 3, at either rate.
- R6: An accepted `pauseReq` keeps `ready` low for 1000 ms, with `dialPulse` and `muteOn` both low.
- R7: `muteOn` is high for the whole of a digit or flash operation and low otherwise. `dialPulse` is never high while `muteOn` is low.
- R8: `ready` is 1 only while the block is idle, and requests presented while `ready` is 0 have no effect. `done` is a single-cycle pulse in the cycle where `ready` returns to 1.
- R9: When requests arrive together, `flashReq` wins over `digitStart`, and `digitStart` wins over `pauseReq`.
- R10: `rateSel`, `ratioSel` and `flashCode` are captured when a request is accepted. Changes to them during the operation do not alter its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| msTick | input | 1 | One-cycle pulse each millisecond |
| rateSel | input | 1 | 0: 10 pulses/s, 1: 20 pulses/s |
| ratioSel | input | 1 | 0: break 60 %, 1: break two thirds |
| digit | input | 4 | Digit to dial, 0 to 9 |
| digitStart | input | 1 | Request to dial `digit` |
| flashReq | input | 1 | Request for a flash break |
| flashCode | input | 2 | Flash length select: 73/100/300/600 ms |
| pauseReq | input | 1 | Request for a 1 s pause |
| dialPulse | output | 1 | 1 = line broken (open-drain transistor on) |
| muteOn | output | 1 | Mute drive, active during digits and flashes |
| ready | output | 1 | Block idle, accepts a request |
| done | output | 1 | One-cycle pulse at the end of an operation |

## Verification
On every cycle the assertions check the following:
- a busy state is left only when the millisecond timer expires;
- each expired break is followed by a make;
- the last make of a digit is followed by the inter-digit gap;
- every timer load is non-zero;
- the pulse counter stays within ten;
- `done` lasts one cycle and coincides with `ready`.

Only the bench scenarios can show the remaining behaviour. These are the pulse counts for each digit, the measured break and make lengths at each rate and ratio, and the flash and pause lengths. They also cover request priority, the ignoring of busy-time and out-of-range requests, and the capture of the configuration inputs.

// File: rtl/pdial_pkg.sv
package pdial_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BREAK,
    ST_MAKE,
    ST_GAP,
    ST_FLASH,
    ST_PAUSE
  } dialState_t;

  typedef enum logic [2:0] {
    DUR_BREAK,
    DUR_MAKE,
    DUR_GAP,
    DUR_FLASH,
    DUR_PAUSE
  } durSel_t;

  // strobes from control to the timing datapath
  typedef struct packed {
    logic    load;     // restart the millisecond counter
    logic    capture;  // latch rate, ratio and flash code
    durSel_t sel;      // which duration to load
  } timerCmd_t;

endpackage

// File: rtl/pdial_timer.sv
module pdial_timer
  import pdial_pkg::*;
#(
  parameter int TIME_W         = 12,
  parameter int SLOW_PERIOD_MS = 100,
  parameter int FAST_PERIOD_MS = 50,
  parameter int PAUSE_MS       = 1000,
  parameter int FLASH_MS0      = 73,
  parameter int FLASH_MS1      = 100,
  parameter int FLASH_MS2      = 300,
  parameter int FLASH_MS3      = 600
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       msTick,
  input  logic       rateSel,
  input  logic       ratioSel,
  input  logic [1:0] flashCode,
  input  timerCmd_t  cmd,
  output logic       expire
);

  logic             capRate;
  logic             capRatio;
  logic [1:0]       capFlash;
  logic             rateNow;
  logic             ratioNow;
  logic [1:0]       flashNow;
  logic [TIME_W-1:0] remain;
  logic [TIME_W-1:0] durMs;
  int unsigned       periodMs;
  int unsigned       breakMs;
  int unsigned       flashMs;

  // configuration is taken from the pins only in the accepting cycle
  assign rateNow  = cmd.capture ? rateSel   : capRate;
  assign ratioNow = cmd.capture ? ratioSel  : capRatio;
  assign flashNow = cmd.capture ? flashCode : capFlash;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capRate  <= 1'b0;
      capRatio <= 1'b0;
      capFlash <= 2'd0;
    end else if (cmd.capture) begin
      capRate  <= rateSel;
      capRatio <= ratioSel;
      capFlash <= flashCode;
    end
  end

  always_comb begin
    periodMs = rateNow ? FAST_PERIOD_MS : SLOW_PERIOD_MS;
    if (ratioNow) breakMs = (periodMs * 2 + 1) / 3;
    else          breakMs = (periodMs * 3) / 5;
    case (flashNow)
      2'd0:    flashMs = FLASH_MS0;
      2'd1:    flashMs = FLASH_MS1;
      2'd2:    flashMs = FLASH_MS2;
      default: flashMs = FLASH_MS3;
    endcase
    case (cmd.sel)
      DUR_BREAK: durMs = TIME_W'(breakMs);
      DUR_MAKE:  durMs = TIME_W'(periodMs - breakMs);
      DUR_GAP:   durMs = TIME_W'(periodMs);
      DUR_FLASH: durMs = TIME_W'(flashMs);
      default:   durMs = TIME_W'(PAUSE_MS);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        remain <= '0;
    else if (cmd.load)                remain <= durMs;
    else if (msTick && remain != '0)  remain <= remain - 1'b1;
  end

  assign expire = msTick && (remain == TIME_W'(1));

  AST_LOAD_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    cmd.load |=> remain != '0); // R3

  AST_TICK_COUNTS: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.load && !msTick) |=> $stable(remain)); // R3

endmodule

// File: rtl/pdial_ctrl.sv
module pdial_ctrl
  import pdial_pkg::*;
#(
  parameter int CNT_W       = 4,
  parameter int MAX_DIGIT   = 9,
  parameter int ZERO_PULSES = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [3:0] digit,
  input  logic       digitStart,
  input  logic       flashReq,
  input  logic       pauseReq,
  input  logic       expire,
  output timerCmd_t  cmd,
  output logic       dialPulse,
  output logic       muteOn,
  output logic       ready,
  output logic       done
);

  dialState_t       state;
  dialState_t       nextState;
  logic [CNT_W-1:0] pulsesLeft;
  logic [CNT_W-1:0] pulsesNext;

  always_comb begin
    nextState  = state;
    pulsesNext = pulsesLeft;
    cmd        = '{load: 1'b0, capture: 1'b0, sel: DUR_BREAK};
    case (state)
      ST_IDLE: begin
        if (flashReq) begin
          nextState   = ST_FLASH;
          cmd.load    = 1'b1;
          cmd.capture = 1'b1;
          cmd.sel     = DUR_FLASH;
        end else if (digitStart && (int'(digit) <= MAX_DIGIT)) begin
          nextState   = ST_BREAK;
          cmd.load    = 1'b1;
          cmd.capture = 1'b1;
          cmd.sel     = DUR_BREAK;
          pulsesNext  = (digit == 4'd0) ? CNT_W'(ZERO_PULSES) : CNT_W'(digit);
        end else if (pauseReq) begin
          nextState   = ST_PAUSE;
          cmd.load    = 1'b1;
          cmd.capture = 1'b1;
          cmd.sel     = DUR_PAUSE;
        end
      end
      ST_BREAK: begin
        if (expire) begin
          nextState  = ST_MAKE;
          cmd.load   = 1'b1;
          cmd.sel    = DUR_MAKE;
          pulsesNext = pulsesLeft - 1'b1;
        end
      end
      ST_MAKE: begin
        if (expire) begin
          cmd.load = 1'b1;
          if (pulsesLeft == '0) begin
            nextState = ST_GAP;
            cmd.sel   = DUR_GAP;
          end else begin
            nextState = ST_BREAK;
            cmd.sel   = DUR_BREAK;
          end
        end
      end
      ST_GAP, ST_FLASH, ST_PAUSE: begin
        if (expire) nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      pulsesLeft <= '0;
      done       <= 1'b0;
    end else begin
      state      <= nextState;
      pulsesLeft <= pulsesNext;
      done       <= (state != ST_IDLE) && (nextState == ST_IDLE);
    end
  end

  assign dialPulse = (state == ST_BREAK) || (state == ST_FLASH);
  assign muteOn    = (state == ST_BREAK) || (state == ST_MAKE) ||
                     (state == ST_GAP)   || (state == ST_FLASH);
  assign ready     = (state == ST_IDLE);

  AST_HOLD_UNTIL_EXPIRE: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE && !expire) |=> state == $past(state)); // R8

  AST_BREAK_TO_MAKE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_BREAK && expire) |=> state == ST_MAKE); // R3

  AST_LAST_MAKE_TO_GAP: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_MAKE && expire && pulsesLeft == '0) |=> state == ST_GAP); // R4

  AST_PULSE_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    int'(pulsesLeft) <= ZERO_PULSES); // R2

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R8

  AST_DONE_WITH_READY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ready); // R8

endmodule

// File: rtl/pulse_dialer.sv
module pulse_dialer
  import pdial_pkg::*;
#(
  parameter int SLOW_PERIOD_MS = 100,
  parameter int FAST_PERIOD_MS = 50,
  parameter int PAUSE_MS       = 1000,
  parameter int FLASH_MS0      = 73,
  parameter int FLASH_MS1      = 100,
  parameter int FLASH_MS2      = 300,
  parameter int FLASH_MS3      = 600,
  parameter int MAX_DIGIT      = 9,
  parameter int ZERO_PULSES    = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       msTick,
  input  logic       rateSel,
  input  logic       ratioSel,
  input  logic [3:0] digit,
  input  logic       digitStart,
  input  logic       flashReq,
  input  logic [1:0] flashCode,
  input  logic       pauseReq,
  output logic       dialPulse,
  output logic       muteOn,
  output logic       ready,
  output logic       done
);

  localparam int TIME_W = $clog2(PAUSE_MS + FLASH_MS3 + SLOW_PERIOD_MS + 1);
  localparam int CNT_W  = $clog2(ZERO_PULSES + 1);

  timerCmd_t timerCmd;
  logic      timerExpire;

  pdial_ctrl #(
    .CNT_W       (CNT_W),
    .MAX_DIGIT   (MAX_DIGIT),
    .ZERO_PULSES (ZERO_PULSES)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .digit      (digit),
    .digitStart (digitStart),
    .flashReq   (flashReq),
    .pauseReq   (pauseReq),
    .expire     (timerExpire),
    .cmd        (timerCmd),
    .dialPulse  (dialPulse),
    .muteOn     (muteOn),
    .ready      (ready),
    .done       (done)
  );

  pdial_timer #(
    .TIME_W         (TIME_W),
    .SLOW_PERIOD_MS (SLOW_PERIOD_MS),
    .FAST_PERIOD_MS (FAST_PERIOD_MS),
    .PAUSE_MS       (PAUSE_MS),
    .FLASH_MS0      (FLASH_MS0),
    .FLASH_MS1      (FLASH_MS1),
    .FLASH_MS2      (FLASH_MS2),
    .FLASH_MS3      (FLASH_MS3)
  ) u_timer (
    .clk       (clk),
    .rstN      (rstN),
    .msTick    (msTick),
    .rateSel   (rateSel),
    .ratioSel  (ratioSel),
    .flashCode (flashCode),
    .cmd       (timerCmd),
    .expire    (timerExpire)
  );

endmodule

// File: tb/pulse_dialer_bench.sv
`timescale 1ns/1ps
module pulse_dialer_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       msTick = 1'b0;
  logic       rateSel = 1'b0;
  logic       ratioSel = 1'b0;
  logic [3:0] digit = 4'd0;
  logic       digitStart = 1'b0;
  logic       flashReq = 1'b0;
  logic [1:0] flashCode = 2'd0;
  logic       pauseReq = 1'b0;
  logic       dialPulse, muteOn, ready, done;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  int tickDiv = 0;
  int brkTicks, makeTicks, idleTicks, pulses, runTicks, badRuns, muteGaps, muteInPause;
  int expRun = 0;
  logic prevPulse = 1'b0;
  logic tickNext;
  logic inDial = 1'b0;
  logic inPause = 1'b0;

  always #2.5 clk = ~clk;

  pulse_dialer u_pulse_dialer (
    .clk(clk), .rstN(rstN), .msTick(msTick), .rateSel(rateSel), .ratioSel(ratioSel),
    .digit(digit), .digitStart(digitStart), .flashReq(flashReq), .flashCode(flashCode),
    .pauseReq(pauseReq), .dialPulse(dialPulse), .muteOn(muteOn), .ready(ready), .done(done)
  );

  function automatic int periodOf(input logic r);
    return r ? 50 : 100;
  endfunction
  function automatic int breakOf(input logic r, input logic q);
    return q ? (periodOf(r) * 2 + 1) / 3 : periodOf(r) * 3 / 5;
  endfunction
  function automatic int makeOf(input logic r, input logic q);
    return periodOf(r) - breakOf(r, q);
  endfunction
  function automatic int flashOf(input logic [1:0] c);
    case (c)
      2'd0: return 73;
      2'd1: return 100;
      2'd2: return 300;
      default: return 600;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 190000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=0", cycles);
      finishRun();
    end
  end

  // millisecond tick every third cycle and port monitor
  always @(negedge clk) begin
    tickNext = (tickDiv == 2);
    tickDiv = (tickDiv == 2) ? 0 : tickDiv + 1;
    msTick <= tickNext;
    if (rstN) begin
      if (prevPulse && !dialPulse) begin
        if (runTicks != expRun) badRuns++;
        runTicks = 0;
      end
      if (dialPulse && !prevPulse) pulses++;
      if (tickNext) begin
        if (dialPulse) begin brkTicks++; runTicks++; end
        else if (muteOn) makeTicks++;
        else if (!ready) idleTicks++;
      end
      if (inDial && !ready && !muteOn) muteGaps++;
      if (inPause && muteOn) muteInPause++;
      if (dialPulse && !muteOn) muteGaps++;
      prevPulse = dialPulse;
    end
  end

  task automatic clearMon();
    brkTicks = 0; makeTicks = 0; idleTicks = 0; pulses = 0;
    runTicks = 0; badRuns = 0; muteGaps = 0; muteInPause = 0;
  endtask

  task automatic waitDone(output int sawReady);
    sawReady = 0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (done) begin sawReady = ready ? 1 : 0; break; end
    end
  endtask

  task automatic strobe(input logic fl, input logic dg, input logic ps);
    flashReq = fl; digitStart = dg; pauseReq = ps;
    @(negedge clk);
    flashReq = 1'b0; digitStart = 1'b0; pauseReq = 1'b0;
  endtask

  task automatic dialDigit(input logic [3:0] d, input logic r, input logic q);
    int n;
    int rdy;
    n = (d == 0) ? 10 : int'(d);
    @(negedge clk);
    clearMon();
    expRun = breakOf(r, q);
    rateSel = r; ratioSel = q; digit = d;
    inDial = 1'b1;
    strobe(1'b0, 1'b1, 1'b0);
    waitDone(rdy);
    inDial = 1'b0;
    check("R2 pulse count", pulses, n);
    check("R3 total break ms", brkTicks, n * breakOf(r, q));
    check("R3 each break ms", badRuns, 0);
    check("R4 make plus gap ms", makeTicks, n * makeOf(r, q) + periodOf(r));
    check("R7 mute held", muteGaps, 0);
    check("R8 ready with done", rdy, 1);
  endtask

  task automatic doFlash(input logic [1:0] c, input logic r);
    int rdy;
    @(negedge clk);
    clearMon();
    expRun = flashOf(c);
    flashCode = c; rateSel = r;
    inDial = 1'b1;
    strobe(1'b1, 1'b0, 1'b0);
    waitDone(rdy);
    inDial = 1'b0;
    check("R5 flash ms", brkTicks, flashOf(c));
    check("R5 flash single break", pulses, 1);
    check("R7 mute in flash", muteGaps, 0);
  endtask

  initial begin
    int seed;
    int rdy;
    seed = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 ready", int'(ready), 1);
    check("R1 dialPulse", int'(dialPulse), 0);
    check("R1 muteOn", int'(muteOn), 0);
    check("R1 done", int'(done), 0);

    // directed corners
    dialDigit(4'd0, 1'b0, 1'b0);
    dialDigit(4'd1, 1'b1, 1'b1);
    dialDigit(4'd9, 1'b1, 1'b0);
    for (int c = 0; c < 4; c++) doFlash(2'(c), 1'(c));

    // pause, R6
    @(negedge clk);
    clearMon();
    inPause = 1'b1;
    strobe(1'b0, 1'b0, 1'b1);
    waitDone(rdy);
    inPause = 1'b0;
    check("R6 pause ms", idleTicks, 1000);
    check("R6 no pulse", pulses, 0);
    check("R6 mute low", muteInPause, 0);

    // out-of-range digit, R2
    @(negedge clk);
    clearMon();
    digit = 4'd12;
    strobe(1'b0, 1'b1, 1'b0);
    repeat (40) @(negedge clk);
    check("R2 invalid digit ready", int'(ready), 1);
    check("R2 invalid digit pulses", pulses, 0);
    check("R2 invalid digit mute", int'(muteOn), 0);

    // priority, R9: flash over digit over pause
    @(negedge clk);
    clearMon();
    expRun = flashOf(2'd1);
    flashCode = 2'd1; digit = 4'd5;
    flashReq = 1'b1; digitStart = 1'b1; pauseReq = 1'b1;
    @(negedge clk);
    flashReq = 1'b0; digitStart = 1'b0; pauseReq = 1'b0;
    waitDone(rdy);
    check("R9 flash wins pulses", pulses, 1);
    check("R9 flash wins ms", brkTicks, 100);
    @(negedge clk);
    clearMon();
    expRun = breakOf(1'b0, 1'b0);
    rateSel = 1'b0; ratioSel = 1'b0; digit = 4'd2;
    digitStart = 1'b1; pauseReq = 1'b1;
    @(negedge clk);
    digitStart = 1'b0; pauseReq = 1'b0;
    waitDone(rdy);
    check("R9 digit over pause", pulses, 2);
    check("R9 no pause time", idleTicks, 0);

    // busy requests ignored, R8
    @(negedge clk);
    clearMon();
    expRun = breakOf(1'b0, 1'b0);
    rateSel = 1'b0; ratioSel = 1'b0; digit = 4'd3;
    strobe(1'b0, 1'b1, 1'b0);
    repeat (100) @(negedge clk);
    digit = 4'd9; flashCode = 2'd3;
    strobe(1'b1, 1'b1, 1'b1);
    waitDone(rdy);
    check("R8 busy request ignored", pulses, 3);
    check("R8 busy break ms", brkTicks, 180);
    repeat (50) @(negedge clk);
    check("R8 stays idle", int'(ready), 1);
    check("R8 no late pulse", int'(dialPulse), 0);

    // configuration captured at start, R10
    @(negedge clk);
    clearMon();
    expRun = breakOf(1'b0, 1'b0);
    rateSel = 1'b0; ratioSel = 1'b0; digit = 4'd2;
    strobe(1'b0, 1'b1, 1'b0);
    repeat (20) @(negedge clk);
    rateSel = 1'b1; ratioSel = 1'b1;
    waitDone(rdy);
    check("R10 break unchanged", brkTicks, 120);
    check("R10 make unchanged", makeTicks, 180);
    check("R10 runs unchanged", badRuns, 0);

    // random digits and flashes
    for (int k = 0; k < 12; k++) begin
      if ($urandom_range(0, 3) == 0) doFlash(2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)));
      else dialDigit(4'($urandom_range(0, 9)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    end

    if (seed == -1) $display("seed");
    finishRun();
  end

endmodule